// File: doc/BRIEF.md
# Sub-Block Scatter DMA Address Sequencer

This block produces buffer-memory addresses for moving sector data between a segmented buffer and a host port. The buffer is divided into numbered segments of a fixed size. Inside each segment, a short list of one to four offset/length windows ("channels") picks the sub-blocks that are sent, so a host can receive only selected parts of each sector. A microcontroller programs the windows, the current segment with its segment count, a queued next segment with its count, and a host byte budget, through a simple single-cycle write port.

The address leaves on a valid/ready stream. `addr_valid` is high while there is budget left in both the byte count and the segment count. The host accepts one byte's address by holding `addr_ready` high on a clock edge where `addr_valid` is high. When `addr_ready` is low the address and all counters hold, and no limit applies to how long. The walk state (segment, channel, offset, bytes left, segments left) is always visible on plain outputs and always names the next byte to move. When the byte budget runs out, a sticky interrupt tells the controller to refill.

Top module: `sbd_scatter_seq`

## Requirements
- R1: `addr_valid` is high exactly when `byte_left` is non-zero, `seg_left` is non-zero and `cfg_we` is low. While it is low, `addr_ready` changes nothing.
- R2: While `addr_valid` is high and `addr_ready` is low, `buf_addr`, `byte_left` and `seg_left` hold their values.
- R3: Each accepted byte lowers `byte_left` by one. Within a channel it also raises `cur_off` by one.
- R4: `buf_addr` equals `cur_seg * SEG_BYTES + cur_off`, with `SEG_BYTES` defaulting to 2352.
- R5: Bits [14:13] of the current-segment register hold a value N, and channels 0..N are walked in order. Each channel starts at its own offset and gives up `length` bytes, where a length of 0 counts as 1. The next channel then begins at its own offset.
- R6: When the last channel of a segment finishes and `seg_left` is above 1, `seg_left` drops by one, `cur_seg` rises by one, and channel 0 restarts.
- R7: When the last channel finishes with `seg_left` equal to 1 and the reload flag (control bit 0) is set, the queued segment (next-segment bits [12:0], channel bits [14:13]) and the queued count are loaded, and the flag clears. Without the flag, `seg_left` becomes 0 and `cur_seg` is kept.
- R8: `irq` sets when an accepted byte takes `byte_left` from 1 to 0. It stays set until control bit 1 is written as 1, or until the byte-count register is written.
- R9: `chan_form` and `chan_autoform` show bits 13 and 14 of the active channel's offset register.
- R10: Register selects: 0 current segment, 1 segment count, 2 next segment, 3 next count, 4 byte count, 5 control, 8+2k channel k offset (bits [11:0]), 9+2k channel k length (bits [11:0]). Writing select 0 restarts at channel 0 with that channel's offset.
- R11: After reset all counters, `cur_seg`, `cur_off`, `cur_chan` and `irq` are 0, and `addr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 16 | Register write data |
| addr_valid | output | 1 | Address offered to host side |
| addr_ready | input | 1 | Host accepts the current byte address |
| buf_addr | output | ADDR_W (25) | Buffer address of next byte |
| chan_form | output | 1 | Form flag of active channel |
| chan_autoform | output | 1 | Autoform flag of active channel |
| cur_seg | output | 13 | Current segment number |
| cur_chan | output | 2 | Active channel |
| cur_off | output | 12 | Byte offset within segment |
| byte_left | output | 16 | Remaining host bytes |
| seg_left | output | 8 | Remaining segments |
| irq | output | 1 | Sticky byte-budget-exhausted interrupt |

## Verification
The main walk is driven with a two-channel layout over two segments, followed by a reload into a one-channel segment. This separates offset stepping inside a channel, channel hand-over, segment increment and the queued-descriptor load, since each produces a different address sequence. A zero-length channel and a stop without reload check the edge handling of the length counter and the segment counter. Stalls on `addr_ready`, strobes with an empty budget and strobes during a register write show that back-pressure and gating leave the state unchanged. The two ways of clearing the interrupt are each checked.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int SEL_W   = 4;
  localparam int CH_BASE = 8;

  typedef enum logic [SEL_W-1:0] {
    RS_CURSEG = 4'd0,
    RS_CURCNT = 4'd1,
    RS_NXTSEG = 4'd2,
    RS_NXTCNT = 4'd3,
    RS_BYTES  = 4'd4,
    RS_CTRL   = 4'd5
  } reg_sel_e;
endpackage

// File: rtl/sbd_chan_bank.sv
module sbd_chan_bank
  import sbd_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int CH_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [OFF_W+2:0]    cfg_wdata,
  input  logic [CH_W-1:0]     ld_idx,
  input  logic [CH_W-1:0]     cur_idx,
  output logic [OFF_W-1:0]    ld_off,
  output logic [OFF_W-1:0]    ld_len,
  output logic                cur_form,
  output logic                cur_autoform
);
  localparam int NCHAN   = 1 << CH_W;
  localparam int FORM_B  = OFF_W + 1;
  localparam int AFORM_B = OFF_W + 2;

  logic [OFF_W-1:0] off_a  [NCHAN];
  logic [OFF_W-1:0] len_a  [NCHAN];
  logic             form_a [NCHAN];
  logic             afrm_a [NCHAN];

  for (genvar g = 0; g < NCHAN; g++) begin : g_ch
    logic [OFF_W-1:0] off_r, len_r;
    logic             form_r, afrm_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        off_r  <= '0;
        len_r  <= '0;
        form_r <= 1'b0;
        afrm_r <= 1'b0;
      end else if (cfg_we) begin
        if (cfg_sel == SEL_W'(CH_BASE + 2*g)) begin
          off_r  <= cfg_wdata[OFF_W-1:0];
          form_r <= cfg_wdata[FORM_B];
          afrm_r <= cfg_wdata[AFORM_B];
        end
        if (cfg_sel == SEL_W'(CH_BASE + 2*g + 1))
          len_r <= cfg_wdata[OFF_W-1:0];
      end
    end
    assign off_a[g]  = off_r;
    assign len_a[g]  = len_r;
    assign form_a[g] = form_r;
    assign afrm_a[g] = afrm_r;
  end

  assign ld_off       = off_a[ld_idx];
  assign ld_len       = len_a[ld_idx];
  assign cur_form     = form_a[cur_idx];
  assign cur_autoform = afrm_a[cur_idx];
endmodule

// File: rtl/sbd_walker.sv
module sbd_walker
  import sbd_pkg::*;
#(
  parameter int SEG_W  = 13,
  parameter int OFF_W  = 12,
  parameter int BCNT_W = 16,
  parameter int SCNT_W = 8,
  parameter int CH_W   = 2,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               addr_ready,
  input  logic [OFF_W-1:0]   ld_off,
  input  logic [OFF_W-1:0]   ld_len,
  output logic [CH_W-1:0]    ld_idx,
  output logic               addr_valid,
  output logic [SEG_W-1:0]   cur_seg,
  output logic [CH_W-1:0]    cur_chan,
  output logic [OFF_W-1:0]   cur_off,
  output logic [BCNT_W-1:0]  byte_left,
  output logic [SCNT_W-1:0]  seg_left,
  output logic               irq
);
  logic [CH_W-1:0]   last_ch, nxt_last_ch;
  logic [SEG_W-1:0]  nxt_seg;
  logic [SCNT_W-1:0] nxt_cnt;
  logic [OFF_W-1:0]  ch_left;
  logic              reload_arm;
  logic              fire, ch_end, seg_end, cseg_wr;

  assign addr_valid = !cfg_we && (byte_left != '0) && (seg_left != '0);
  assign fire       = addr_valid && addr_ready;
  assign ch_end     = (ch_left <= OFF_W'(1));
  assign seg_end    = ch_end && (cur_chan == last_ch);
  assign cseg_wr    = cfg_we && (cfg_sel == RS_CURSEG);
  assign ld_idx     = (cseg_wr || seg_end) ? '0 : cur_chan + CH_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_seg     <= '0;
      cur_chan    <= '0;
      cur_off     <= '0;
      ch_left     <= '0;
      byte_left   <= '0;
      seg_left    <= '0;
      last_ch     <= '0;
      nxt_seg     <= '0;
      nxt_last_ch <= '0;
      nxt_cnt     <= '0;
      reload_arm  <= 1'b0;
      irq         <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        RS_CURSEG: begin
          cur_seg  <= cfg_wdata[SEG_W-1:0];
          last_ch  <= cfg_wdata[SEG_W+CH_W-1:SEG_W];
          cur_chan <= '0;
          cur_off  <= ld_off;
          ch_left  <= ld_len;
        end
        RS_CURCNT: seg_left <= cfg_wdata[SCNT_W-1:0];
        RS_NXTSEG: begin
          nxt_seg     <= cfg_wdata[SEG_W-1:0];
          nxt_last_ch <= cfg_wdata[SEG_W+CH_W-1:SEG_W];
        end
        RS_NXTCNT: nxt_cnt <= cfg_wdata[SCNT_W-1:0];
        RS_BYTES: begin
          byte_left <= cfg_wdata[BCNT_W-1:0];
          irq       <= 1'b0;
        end
        RS_CTRL: begin
          reload_arm <= cfg_wdata[0];
          if (cfg_wdata[1]) irq <= 1'b0;
        end
        default: ;
      endcase
    end else if (fire) begin
      byte_left <= byte_left - BCNT_W'(1);
      if (byte_left == BCNT_W'(1)) irq <= 1'b1;
      if (!ch_end) begin
        cur_off <= cur_off + OFF_W'(1);
        ch_left <= ch_left - OFF_W'(1);
      end else begin
        cur_off <= ld_off;
        ch_left <= ld_len;
        if (!seg_end) begin
          cur_chan <= cur_chan + CH_W'(1);
        end else begin
          cur_chan <= '0;
          if (seg_left != SCNT_W'(1)) begin
            seg_left <= seg_left - SCNT_W'(1);
            cur_seg  <= cur_seg + SEG_W'(1);
          end else if (reload_arm) begin
            cur_seg    <= nxt_seg;
            last_ch    <= nxt_last_ch;
            seg_left   <= nxt_cnt;
            reload_arm <= 1'b0;
          end else begin
            seg_left <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sbd_scatter_seq.sv
module sbd_scatter_seq
  import sbd_pkg::*;
#(
  parameter int SEG_W     = 13,
  parameter int OFF_W     = 12,
  parameter int BCNT_W    = 16,
  parameter int SCNT_W    = 8,
  parameter int CH_W      = 2,
  parameter int DATA_W    = 16,
  parameter int SEG_BYTES = 2352,
  parameter int ADDR_W    = SEG_W + $clog2(SEG_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic               addr_valid,
  input  logic               addr_ready,
  output logic [ADDR_W-1:0]  buf_addr,
  output logic               chan_form,
  output logic               chan_autoform,
  output logic [SEG_W-1:0]   cur_seg,
  output logic [CH_W-1:0]    cur_chan,
  output logic [OFF_W-1:0]   cur_off,
  output logic [BCNT_W-1:0]  byte_left,
  output logic [SCNT_W-1:0]  seg_left,
  output logic               irq
);
  logic [CH_W-1:0]  ld_idx;
  logic [OFF_W-1:0] ld_off, ld_len;

  sbd_chan_bank #(.OFF_W(OFF_W), .CH_W(CH_W)) u_bank (
    .clk, .rst_n, .cfg_we, .cfg_sel,
    .cfg_wdata    (cfg_wdata[OFF_W+2:0]),
    .ld_idx, .cur_idx(cur_chan),
    .ld_off, .ld_len,
    .cur_form     (chan_form),
    .cur_autoform (chan_autoform)
  );

  sbd_walker #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .BCNT_W(BCNT_W),
    .SCNT_W(SCNT_W), .CH_W(CH_W), .DATA_W(DATA_W)
  ) u_walk (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .addr_ready,
    .ld_off, .ld_len, .ld_idx, .addr_valid,
    .cur_seg, .cur_chan, .cur_off, .byte_left, .seg_left, .irq
  );

  assign buf_addr = ADDR_W'(cur_seg) * ADDR_W'(SEG_BYTES) + ADDR_W'(cur_off);
endmodule

// File: rtl/sbd_scatter_seq_chk.sv
module sbd_scatter_seq_chk #(
  parameter int ADDR_W = 25,
  parameter int BCNT_W = 16,
  parameter int SCNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] buf_addr,
  input logic [BCNT_W-1:0] byte_left,
  input logic [SCNT_W-1:0] seg_left,
  input logic              irq
);
  a_r1_empty_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_left == '0 || seg_left == '0) |-> !addr_valid);

  a_r1_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !addr_valid);

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !cfg_we) |=>
      ($stable(buf_addr) && $stable(byte_left) && $stable(seg_left)));

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready) |=> (byte_left == $past(byte_left) - BCNT_W'(1)));

  a_r8_irq_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && byte_left == BCNT_W'(1)) |=> irq);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cfg_we) |=> irq);
endmodule

bind sbd_scatter_seq sbd_scatter_seq_chk #(
  .ADDR_W(ADDR_W), .BCNT_W(BCNT_W), .SCNT_W(SCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .addr_valid(addr_valid),
  .addr_ready(addr_ready), .buf_addr(buf_addr), .byte_left(byte_left),
  .seg_left(seg_left), .irq(irq)
);

// File: tb/test_sbd_scatter_seq.sv
module test_sbd_scatter_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SEGB = 2352;
  localparam int NV = 13;
  // {autoform, form, segment[12:0], offset[11:0]}
  localparam logic [26:0] VEC [0:NV-1] = '{
    {1'b0,1'b1,13'd5,12'd12}, {1'b0,1'b1,13'd5,12'd13}, {1'b0,1'b1,13'd5,12'd14},
    {1'b1,1'b0,13'd5,12'd100},{1'b1,1'b0,13'd5,12'd101},
    {1'b0,1'b1,13'd6,12'd12}, {1'b0,1'b1,13'd6,12'd13}, {1'b0,1'b1,13'd6,12'd14},
    {1'b1,1'b0,13'd6,12'd100},{1'b1,1'b0,13'd6,12'd101},
    {1'b0,1'b1,13'd40,12'd12},{1'b0,1'b1,13'd40,12'd13},{1'b0,1'b1,13'd40,12'd14}
  };

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, addr_ready = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic addr_valid, chan_form, chan_autoform, irq;
  logic [24:0] buf_addr;
  logic [12:0] cur_seg;
  logic [1:0] cur_chan;
  logic [11:0] cur_off;
  logic [15:0] byte_left;
  logic [7:0] seg_left;
  int runs = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbd_scatter_seq i_sbd_scatter_seq (.*);

  task automatic chk(string tag, longint act, longint exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] s, logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; #1;
  endtask

  task automatic step();
    @(negedge clk); addr_ready = 1'b1;
    @(negedge clk); addr_ready = 1'b0; #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    chk("R11 valid", addr_valid, 0);
    chk("R11 byte_left", byte_left, 0);
    chk("R11 seg_left", seg_left, 0);
    chk("R11 irq", irq, 0);
    chk("R11 cur_seg", cur_seg, 0);

    wr(4'd8,  16'h200C);  // ch0 off 12, form
    wr(4'd9,  16'd3);
    wr(4'd10, 16'h4064);  // ch1 off 100, autoform
    wr(4'd11, 16'd2);
    wr(4'd0,  16'h2005);  // seg 5, channels 0..1
    wr(4'd1,  16'd2);
    wr(4'd2,  16'd40);    // next seg 40, channel 0 only
    wr(4'd3,  16'd1);
    wr(4'd5,  16'd1);     // arm reload
    wr(4'd4,  16'd13);
    chk("R10 cur_off after seg write", cur_off, 12);
    chk("R10 seg_left", seg_left, 2);

    for (int i = 0; i < NV; i++) begin
      chk("R4 buf_addr", buf_addr, VEC[i][24:12] * SEGB + VEC[i][11:0]);
      chk("R6 R7 cur_seg", cur_seg, VEC[i][24:12]);
      chk("R5 cur_off", cur_off, VEC[i][11:0]);
      chk("R9 form", chan_form, VEC[i][25]);
      chk("R9 autoform", chan_autoform, VEC[i][26]);
      chk("R3 byte_left", byte_left, NV - i);
      chk("R6 seg_left", seg_left, (i < 5) ? 2 : 1);
      if (i == 3) begin
        repeat (3) @(negedge clk);
        #1;
        chk("R2 stall addr", buf_addr, 5 * SEGB + 100);
        chk("R2 stall count", byte_left, NV - 3);
      end
      step();
    end

    chk("R1 valid at end", addr_valid, 0);
    chk("R7 no reload stop", seg_left, 0);
    chk("R8 irq set", irq, 1);
    step();
    chk("R1 ignored strobe off", cur_off, 12);
    chk("R1 ignored strobe seg", cur_seg, 40);
    wr(4'd5, 16'h0002);
    chk("R8 irq cleared by control", irq, 0);

    // zero-length channel 0 behaves as one byte
    wr(4'd8,  16'd7);
    wr(4'd9,  16'd0);
    wr(4'd10, 16'd50);
    wr(4'd11, 16'd1);
    wr(4'd0,  16'h2003);
    wr(4'd1,  16'd1);
    wr(4'd4,  16'd5);
    chk("R5 start off", cur_off, 7);
    step();
    chk("R5 zero len hands over", cur_off, 50);
    chk("R5 chan", cur_chan, 1);
    step();
    chk("R7 stop without reload", seg_left, 0);
    chk("R7 seg kept", cur_seg, 3);
    chk("R3 byte_left", byte_left, 3);
    chk("R1 valid low", addr_valid, 0);

    wr(4'd1, 16'd1);
    wr(4'd0, 16'h2003);
    wr(4'd4, 16'd1);
    step();
    chk("R8 irq from last byte", irq, 1);
    wr(4'd4, 16'd2);
    chk("R8 irq cleared by byte write", irq, 0);

    @(negedge clk); cfg_we = 1'b1; cfg_sel = 4'd5; cfg_wdata = 16'd0; #1;
    chk("R1 valid low during write", addr_valid, 0);
    @(negedge clk); cfg_we = 1'b0; #1;
    chk("R1 valid after write", addr_valid, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule